// File: doc/BRIEF.md
# Six-Channel Pulse-Width Modulator with Staged Configuration

This block generates one pulse-width modulated waveform per channel, six channels by default, each run from the block clock. Software reaches every channel through its own 32-byte window on a simple 32-bit register bus. A channel counts clock cycles through a programmable period. For the first part of each period, set by a duty count, the channel drives one level, and for the rest of the period it drives the opposite level.

New period and duty counts are first written into staging registers, which do not affect the output. A self-clearing commit bit in the control register then moves both counts into the running counter at the same moment. On a running channel the move waits for the end of the current period. On a stopped channel it happens at once. The polarity bit, the run bit and the stopped-level bit act on the output directly.

Each channel keeps a sticky period-complete flag that a status read clears. The flag raises the channel's interrupt line when that channel's interrupt enable bit is set.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output and interrupt line is low and every register of every channel reads zero.
- R2: Channel n answers at byte addresses n*0x20 to n*0x20+0x1F. Within the window the word offsets are: control at +0x00, repeat at +0x04, period at +0x08, duty at +0x0C and status at +0x10. The repeat register stores and returns a full 32-bit word. Unused offsets and channel numbers of 6 and above read zero, and writes to them have no effect.
- R3: The control bits are: bit0 run, bit1 counter restart, bit2 commit, bit3 interrupt enable, bits 4 to 7 mode bits, bit8 first-phase level, bit9 stopped level. The mode bits are stored and read back but have no effect on the output. Bit1 always reads 0.
- R4: While a channel runs with committed period P>0 and duty D, its count steps 0 to P-1 and repeats. The output shows the first-phase level while the count is below D and the opposite level otherwise. If D>=P the output stays at the first-phase level. If D=0, or if P=0, the output stays at the opposite level.
- R5: Writes to the period and duty registers read back at once but do not change the output until a commit.
- R6: A commit on a running channel loads period and duty together after the last count of the current period. Control bit2 reads 1 until that load happens.
- R7: A commit on a stopped channel loads the staged values on the next clock, and bit2 then reads 0.
- R8: A change of the first-phase level bit changes the output on the clock after the write, without a commit.
- R9: While run is 0, the output equals the stopped-level bit. Clearing run resets the count, so a restart begins at count 0 with the committed values.
- R10: Writing 1 to bit1 returns the count to 0 on the following clock, and the bit clears itself.
- R11: Status bit0 is set at the end of every completed period and stays set until a status read. A read in the same cycle as a period end leaves it set.
- R12: Each interrupt line is high exactly when that channel's status bit0 and its interrupt enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it also sets the unit of the period and duty counts |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| pwm_out | output | NUM_CH (6) | One waveform per channel |
| irq | output | NUM_CH (6) | Per-channel interrupt, level |

## Verification
Two functions can fall in the same clock: a period end that sets the status flag, and a status read that clears it. A commit on a running channel can also land on the same clock as the period end that applies it. The bench holds status reads for several back-to-back cycles on channels with short periods, and it issues random commits and reads while channels run, so both coincidences occur many times. A cycle-level reference model, written from the requirements, gives the expected flag, read data and waveform in every cycle. The flag must survive a coincident read, and the waveform must never show a new period together with an old duty.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int unsigned BUS_W   = 32;
  localparam int unsigned WIN_LSB = 5;   // 32-byte window per channel

  // word offsets inside a channel window
  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_RPT  = 3'd1;
  localparam logic [2:0] OFS_PER  = 3'd2;
  localparam logic [2:0] OFS_DUTY = 3'd3;
  localparam logic [2:0] OFS_STAT = 3'd4;

  // control bit positions
  localparam int unsigned B_RUN   = 0;
  localparam int unsigned B_RST   = 1;
  localparam int unsigned B_COMMIT = 2;
  localparam int unsigned B_IEN   = 3;
  localparam int unsigned B_MODE0 = 4;   // bits 4..7: stored mode bits
  localparam int unsigned B_FPLVL = 8;
  localparam int unsigned B_STLVL = 9;

  typedef struct packed {
    logic       stop_lvl;
    logic       fp_lvl;
    logic [3:0] mode;
    logic       ien;
    logic       run;
  } chan_ctrl_t;

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_bank_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       ofs,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  input  logic             load,
  input  logic             wrap,
  output logic             run,
  output logic             fp_lvl,
  output logic             stop_lvl,
  output logic             ien,
  output logic             cnt_rst,
  output logic             commit_pend,
  output logic [CNT_W-1:0] per_stage,
  output logic [CNT_W-1:0] duty_stage,
  output logic             done_flag
);

  chan_ctrl_t       ctrl_q, ctrl_d;
  logic [BUS_W-1:0] rpt_q;
  logic [CNT_W-1:0] per_q, duty_q;
  logic             pend_q, pend_d;
  logic             rst_q, rst_d;
  logic             stat_q, stat_d;
  logic             wr_ctrl, wr_rpt, wr_per, wr_duty, rd_stat;

  assign wr_ctrl = wr_en && (ofs == OFS_CTRL);
  assign wr_rpt  = wr_en && (ofs == OFS_RPT);
  assign wr_per  = wr_en && (ofs == OFS_PER);
  assign wr_duty = wr_en && (ofs == OFS_DUTY);
  assign rd_stat = rd_en && (ofs == OFS_STAT);

  // next-state
  always_comb begin
    ctrl_d.run      = wdata[B_RUN];
    ctrl_d.ien      = wdata[B_IEN];
    ctrl_d.mode     = wdata[B_MODE0 +: 4];
    ctrl_d.fp_lvl   = wdata[B_FPLVL];
    ctrl_d.stop_lvl = wdata[B_STLVL];
    pend_d = (pend_q && !load) || (wr_ctrl && wdata[B_COMMIT]);
    rst_d  = wr_ctrl && wdata[B_RST];
    stat_d = wrap || (stat_q && !rd_stat);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rpt_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
      pend_q <= 1'b0;
      rst_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_rpt)  rpt_q  <= wdata;
      if (wr_per)  per_q  <= wdata[CNT_W-1:0];
      if (wr_duty) duty_q <= wdata[CNT_W-1:0];
      pend_q <= pend_d;
      rst_q  <= rst_d;
      stat_q <= stat_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (ofs)
      OFS_CTRL: begin
        rdata[B_RUN]        = ctrl_q.run;
        rdata[B_COMMIT]     = pend_q;
        rdata[B_IEN]        = ctrl_q.ien;
        rdata[B_MODE0 +: 4] = ctrl_q.mode;
        rdata[B_FPLVL]      = ctrl_q.fp_lvl;
        rdata[B_STLVL]      = ctrl_q.stop_lvl;
      end
      OFS_RPT:  rdata = rpt_q;
      OFS_PER:  rdata = BUS_W'(per_q);
      OFS_DUTY: rdata = BUS_W'(duty_q);
      OFS_STAT: rdata[0] = stat_q;
      default:  rdata = '0;
    endcase
  end

  assign run         = ctrl_q.run;
  assign fp_lvl      = ctrl_q.fp_lvl;
  assign stop_lvl    = ctrl_q.stop_lvl;
  assign ien         = ctrl_q.ien;
  assign cnt_rst     = rst_q;
  assign commit_pend = pend_q;
  assign per_stage   = per_q;
  assign duty_stage  = duty_q;
  assign done_flag   = stat_q;

  // R6: a load retires the commit unless a new commit arrives with it
  assert_commit_retires_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !(wr_ctrl && wdata[B_COMMIT])) |=> !commit_pend);

  // R11: a period end always leaves the flag set
  assert_wrap_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> done_flag);

  // R11: only a status read clears the flag
  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !rd_stat) |=> done_flag);

  // R10: the restart request lasts one cycle unless rewritten
  assert_restart_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rst && !wr_ctrl) |=> !cnt_rst);

endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             fp_lvl,
  input  logic             stop_lvl,
  input  logic             cnt_rst,
  input  logic             commit_pend,
  input  logic [CNT_W-1:0] per_stage,
  input  logic [CNT_W-1:0] duty_stage,
  output logic             load,
  output logic             wrap,
  output logic             pwm_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_q, duty_q;
  logic             per_zero, at_last, first_phase, cnt_clr;

  assign per_zero = (per_q == '0);
  assign at_last  = (cnt_q == per_q - CNT_W'(1));
  assign wrap     = run && !per_zero && !cnt_rst && at_last;
  // staged values move only where a period boundary cannot be torn
  assign load     = commit_pend && (!run || per_zero || wrap);
  assign cnt_clr  = !run || cnt_rst || per_zero || wrap;

  always_comb begin
    cnt_d = cnt_clr ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (load) begin
        per_q  <= per_stage;
        duty_q <= duty_stage;
      end
    end
  end

  assign first_phase = !per_zero && (cnt_q < duty_q);
  assign pwm_o = run ? (first_phase ? fp_lvl : !fp_lvl) : stop_lvl;

  // R4: the count never reaches the committed period while running
  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !per_zero) |-> (cnt_q < per_q));

  // R4: every period end restarts the count
  assert_wrap_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));

  // R6: the active counts change only through a load
  assert_active_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(per_q) && $stable(duty_q)));

  // R9: a stopped channel restarts from zero
  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] irq
);

  localparam int unsigned CH_W = ADDR_W - WIN_LSB;

  logic [CH_W-1:0]  ch_idx;
  logic [2:0]       ofs;
  logic             unused_addr_lsb;
  logic [BUS_W-1:0] ch_rdata [NUM_CH];

  assign ch_idx          = bus_addr[ADDR_W-1:WIN_LSB];
  assign ofs             = bus_addr[WIN_LSB-1:2];
  assign unused_addr_lsb = ^bus_addr[1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic             hit, run, fp_lvl, stop_lvl, ien, cnt_rst, pend;
    logic             load, wrap, done;
    logic [CNT_W-1:0] per_stage, duty_stage;

    assign hit = bus_sel && (ch_idx == CH_W'(g));

    pwm_chan_regs #(.CNT_W(CNT_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (hit && bus_wr),
      .rd_en       (hit && !bus_wr),
      .ofs         (ofs),
      .wdata       (bus_wdata),
      .rdata       (ch_rdata[g]),
      .load        (load),
      .wrap        (wrap),
      .run         (run),
      .fp_lvl      (fp_lvl),
      .stop_lvl    (stop_lvl),
      .ien         (ien),
      .cnt_rst     (cnt_rst),
      .commit_pend (pend),
      .per_stage   (per_stage),
      .duty_stage  (duty_stage),
      .done_flag   (done)
    );

    pwm_chan_core #(.CNT_W(CNT_W)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .fp_lvl      (fp_lvl),
      .stop_lvl    (stop_lvl),
      .cnt_rst     (cnt_rst),
      .commit_pend (pend),
      .per_stage   (per_stage),
      .duty_stage  (duty_stage),
      .load        (load),
      .wrap        (wrap),
      .pwm_o       (pwm_out[g])
    );

    assign irq[g] = done && ien;
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_idx == CH_W'(i)) bus_rdata = ch_rdata[i];
    end
  end

endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 6;
  localparam int WD_LIMIT   = 100000;

  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [NUM_CH-1:0] pwm_out, irq;

  pwm_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_tag = "R1";
  bit    mon_en = 0;

  // reference model state, derived from the requirements
  logic [9:0]  m_ctl  [NUM_CH];
  logic [31:0] m_rpt  [NUM_CH];
  logic [31:0] m_psh  [NUM_CH];
  logic [31:0] m_dsh  [NUM_CH];
  logic [31:0] m_pa   [NUM_CH];
  logic [31:0] m_da   [NUM_CH];
  logic [31:0] m_cnt  [NUM_CH];
  bit          m_pend [NUM_CH];
  bit          m_rst  [NUM_CH];
  bit          m_stat [NUM_CH];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic exp_out(input int c);
    bit run, fp;
    run = m_ctl[c][0];
    fp  = m_ctl[c][8];
    if (!run) return m_ctl[c][9];
    if (m_pa[c] != 0 && m_cnt[c] < m_da[c]) return fp;
    return !fp;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    int c;
    c = int'(a[7:5]);
    if (c >= NUM_CH) return 32'h0;
    case (a[4:2])
      3'd0: return {22'h0, m_ctl[c][9:3], m_pend[c], 1'b0, m_ctl[c][0]};
      3'd1: return m_rpt[c];
      3'd2: return m_psh[c];
      3'd3: return m_dsh[c];
      3'd4: return {31'h0, m_stat[c]};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        m_ctl[c] = '0; m_rpt[c] = '0; m_psh[c] = '0; m_dsh[c] = '0;
        m_pa[c] = '0; m_da[c] = '0; m_cnt[c] = '0;
        m_pend[c] = 0; m_rst[c] = 0; m_stat[c] = 0;
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        bit hit, wr, rd, wrp, ld, run;
        logic [2:0] o;
        hit = bus_sel && (int'(bus_addr[7:5]) == c);
        o   = bus_addr[4:2];
        wr  = hit && bus_wr;
        rd  = hit && !bus_wr;
        run = m_ctl[c][0];
        wrp = run && m_pa[c] != 0 && !m_rst[c] && (m_cnt[c] == m_pa[c] - 1);
        ld  = m_pend[c] && (!run || m_pa[c] == 0 || wrp);
        if (!run || m_rst[c] || m_pa[c] == 0 || wrp) m_cnt[c] = 0;
        else m_cnt[c] = m_cnt[c] + 1;
        if (ld) begin m_pa[c] = m_psh[c]; m_da[c] = m_dsh[c]; end
        m_stat[c] = wrp || (m_stat[c] && !(rd && o == 3'd4));
        m_pend[c] = m_pend[c] && !ld;
        m_rst[c]  = 0;
        if (wr) begin
          case (o)
            3'd0: begin
              m_ctl[c]  = bus_wdata[9:0];
              m_pend[c] = m_pend[c] || bus_wdata[2];
              m_rst[c]  = bus_wdata[1];
            end
            3'd1: m_rpt[c] = bus_wdata;
            3'd2: m_psh[c] = bus_wdata;
            3'd3: m_dsh[c] = bus_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  // per-cycle waveform and interrupt comparison against the model
  always @(negedge clk) begin
    if (mon_en) begin
      logic [NUM_CH-1:0] eo, ei;
      for (int c = 0; c < NUM_CH; c++) begin
        eo[c] = exp_out(c);
        ei[c] = m_stat[c] && m_ctl[c][3];
      end
      check(cur_tag, 32'(pwm_out), 32'(eo), "pwm_out");
      check("R12", 32'(irq), 32'(ei), "irq");
    end
  end

  function automatic logic [7:0] adr(input int c, input int o);
    return 8'(c * 32 + o * 4);
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, input string tag, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1;
    v = bus_rdata;
    check(tag, bus_rdata, exp_rd(a), "model read");
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic read_hold(input logic [7:0] a, input int n, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    for (int i = 0; i < n; i++) begin
      #1;
      check(tag, bus_rdata, exp_rd(a), "held read");
      @(negedge clk);
    end
    bus_sel = 0;
  endtask

  task automatic count_high(input int c, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      if (pwm_out[c]) hi++;
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1: actual %0d cycles expected fewer", WD_LIMIT);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int hi;
    void'($urandom(32'd20240917));
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1", 32'(pwm_out), 32'h0, "pwm_out in reset");
    check("R1", 32'(irq), 32'h0, "irq in reset");
    rst_n = 1;
    mon_en = 1;
    bus_read(adr(0, 0), "R1", v);
    check("R1", v, 32'h0, "ctrl after reset");
    bus_read(adr(5, 4), "R1", v);
    check("R1", v, 32'h0, "status after reset");

    // R2: address map and out-of-range channels
    cur_tag = "R2";
    bus_write(adr(3, 1), 32'hA5A5_1234);
    bus_read(adr(3, 1), "R2", v);
    check("R2", v, 32'hA5A5_1234, "repeat readback");
    bus_write(adr(6, 2), 32'h55);
    bus_read(adr(6, 2), "R2", v);
    check("R2", v, 32'h0, "channel 6 period");
    bus_read(adr(7, 0), "R2", v);
    check("R2", v, 32'h0, "channel 7 ctrl");
    bus_read(adr(3, 6), "R2", v);
    check("R2", v, 32'h0, "unused offset");

    // R3: stored mode bits, restart bit reads zero
    cur_tag = "R3";
    bus_write(adr(4, 0), 32'h0000_02F2);
    bus_read(adr(4, 0), "R3", v);
    check("R3", v, 32'h0000_02F0, "ctrl readback");
    bus_write(adr(4, 0), 32'h0);

    // R5/R7: staging and commit on a stopped channel
    cur_tag = "R7";
    bus_write(adr(0, 2), 32'd5);
    bus_write(adr(0, 3), 32'd2);
    bus_read(adr(0, 2), "R5", v);
    check("R5", v, 32'd5, "period stage readback");
    bus_write(adr(0, 0), 32'h104);
    bus_read(adr(0, 0), "R7", v);
    check("R7", v, 32'h100, "commit retired while stopped");

    // R4: duty 2 of period 5
    cur_tag = "R4";
    bus_write(adr(0, 0), 32'h101);
    count_high(0, 10, hi);
    check("R4", 32'(hi), 32'd4, "high cycles in two periods");

    // R5: staged duty has no effect yet
    cur_tag = "R5";
    bus_write(adr(0, 3), 32'd4);
    count_high(0, 10, hi);
    check("R5", 32'(hi), 32'd4, "staged duty without commit");

    // R6: commit on running channel
    cur_tag = "R6";
    bus_write(adr(0, 0), 32'h105);
    bus_read(adr(0, 0), "R6", v);
    repeat (8) @(negedge clk);
    count_high(0, 10, hi);
    check("R6", 32'(hi), 32'd8, "duty 4 of 5 after boundary");

    // R10: restart bit
    cur_tag = "R10";
    bus_write(adr(0, 0), 32'h103);
    bus_read(adr(0, 0), "R10", v);
    check("R10", v, 32'h101, "restart bit self-clears");
    repeat (6) @(negedge clk);

    // R8: polarity acts at once (period 0 holds the opposite level)
    cur_tag = "R8";
    bus_write(adr(2, 0), 32'h105);
    #1 check("R8", 32'(pwm_out[2]), 32'h0, "fp=1 period 0");
    bus_write(adr(2, 0), 32'h001);
    #1 check("R8", 32'(pwm_out[2]), 32'h1, "fp=0 period 0");

    // R9: stopped level
    cur_tag = "R9";
    bus_write(adr(2, 0), 32'h200);
    #1 check("R9", 32'(pwm_out[2]), 32'h1, "stopped level 1");
    bus_write(adr(2, 0), 32'h000);
    #1 check("R9", 32'(pwm_out[2]), 32'h0, "stopped level 0");
    bus_write(adr(0, 0), 32'h100);
    bus_write(adr(0, 0), 32'h101);
    count_high(0, 5, hi);
    check("R9", 32'(hi), 32'd4, "restart with committed values");

    // R11: status set vs read clear in the same cycle
    cur_tag = "R11";
    bus_write(adr(1, 2), 32'd4);
    bus_write(adr(1, 3), 32'd1);
    bus_write(adr(1, 0), 32'h105);
    read_hold(adr(1, 4), 14, "R11");
    bus_write(adr(1, 0), 32'h100);
    bus_read(adr(1, 4), "R11", v);
    bus_read(adr(1, 4), "R11", v);
    check("R11", v, 32'h0, "flag cleared by read");

    // R12: interrupt enable
    cur_tag = "R12";
    bus_write(adr(1, 0), 32'h109);
    count_high(1, 1, hi);
    repeat (6) @(negedge clk);
    #1 check("R12", 32'(irq[1]), 32'h1, "irq raised after period end");
    bus_write(adr(1, 0), 32'h101);
    #1 check("R12", 32'(irq[1]), 32'h0, "irq masked");

    // constrained random traffic
    cur_tag = "R4";
    for (int k = 0; k < 3000; k++) begin
      int op, c;
      op = $urandom_range(0, 9);
      c  = $urandom_range(0, NUM_CH - 1);
      case (op)
        0, 1, 2, 3: @(negedge clk);
        4: bus_write(adr(c, 2), 32'($urandom_range(0, 10)));
        5: bus_write(adr(c, 3), 32'($urandom_range(0, 12)));
        6: begin
          logic [31:0] d;
          d = $urandom & 32'h3F8;
          d[0] = ($urandom_range(0, 3) != 0);
          d[1] = ($urandom_range(0, 15) == 0);
          d[2] = $urandom_range(0, 1);
          bus_write(adr(c, 0), d);
        end
        7, 8: bus_read(8'($urandom_range(0, 255)), "R2", v);
        default: read_hold(adr(c, 4), 3, "R11");
      endcase
    end

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule